// File: doc/BRIEF.md
# Highway and Farm Road Crossing Light Sequencer

This block controls the signal lamps at the crossing of a busy highway with a lightly used farm road. At reset the highway shows green and the farm road shows red. The highway keeps green for at least one long interval, 30 seconds by default, and then for as long as no vehicle waits on the farm road. A vehicle sensor on the farm road is asynchronous to the clock, so it passes through a flip-flop synchronizer before the sequencer uses it. When a waiting vehicle is seen and the long interval has expired, the highway goes yellow for a short interval (5 seconds). Both roads then show red for one clock. The farm road then gets green for a long interval, yellow for a short interval, and one clock of all red. After that the highway is green again.

Intervals come from a built-in timer. A prescaler turns the system clock (13.1 kHz by default) into a one-second tick. A chain of parallel-loadable 4-bit down counters counts these ticks. On entry to every green or yellow phase the sequencer raises a one-clock load strobe, together with a select strobe for either the long or the short interval. All strobes and lamp outputs come straight from flip-flops, so they carry no combinational glitches. The timer reports completion when every counter stage reads zero. The prescaler restarts on each load, so every interval is whole.

Top module: `farm_hwy_ctrl`

## Requirements
- R1: While reset is applied and right after it, the highway shows green, the farm road shows red, and `load_cnt`, `start_long` and `start_short` are low.
- R2: On each road exactly one of the red, yellow and green outputs is high in every cycle.
- R3: A green lamp never changes directly to red. When a road's green goes low, that road's yellow is high in the same cycle.
- R4: The timer is initialized to the long interval at reset. With the sensor held active, highway green ends at the clock edge numbered LONG_SEC*TICK_DIV+1 after reset release. When highway green is entered later, it ends LONG_SEC*TICK_DIV+2 edges after entry.
- R5: Once its minimum interval has expired, highway green holds while the synchronized sensor is low. A sensor rise placed between two edges ends highway green at the third following edge.
- R6: Each yellow phase, on either road, lasts SHORT_SEC*TICK_DIV+2 clock cycles.
- R7: After each yellow phase both roads show red for exactly one cycle. The other road's green follows.
- R8: Farm green lasts LONG_SEC*TICK_DIV+2 cycles, whatever the sensor does.
- R9: In the first cycle of every green or yellow phase after reset, `load_cnt` is high for that single cycle. It comes with `start_long`=1 for green and with `start_short`=1 for yellow, and the other select strobe stays low. In all other cycles the three strobes are low.
- R10: At least one of the two roads shows red in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (13.1 kHz by default) |
| rst_n | input | 1 | Active-low reset |
| farm_sensor_async | input | 1 | Farm-road vehicle sensor, asynchronous |
| hwy_red | output | 1 | Highway red lamp |
| hwy_yellow | output | 1 | Highway yellow lamp |
| hwy_green | output | 1 | Highway green lamp |
| farm_red | output | 1 | Farm-road red lamp |
| farm_yellow | output | 1 | Farm-road yellow lamp |
| farm_green | output | 1 | Farm-road green lamp |
| start_long | output | 1 | Registered strobe selecting the long interval |
| start_short | output | 1 | Registered strobe selecting the short interval |
| load_cnt | output | 1 | Registered, glitch-free counter load strobe |

## Verification
The bench uses a prescaler of 3 so that the runs stay short. It derives every duration from the register path: a strobe registered on phase entry, a timer load on the next edge, LONG_SEC or SHORT_SEC ticks of TICK_DIV cycles each, and one more edge for the sequencer to react. This gives N*TICK_DIV+2 cycles per timed phase. It gives one edge less after reset, because there the counters start preloaded. A sensor change is applied between edges and is due three edges later: two synchronizer flops and the state register. The bench samples one time unit after each rising edge. It counts edges until the lamp pattern changes and compares that count exactly. It checks the strobes in the entry cycle and again one cycle later.

// File: rtl/fh_ctrl_pkg.sv
package fh_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_HWY_GO,
        PH_HWY_WARN,
        PH_TO_FARM,
        PH_FARM_GO,
        PH_FARM_WARN,
        PH_TO_HWY
    } phase_e;

    typedef struct packed {
        logic red;
        logic yellow;
        logic green;
    } lamp_t;

    typedef struct packed {
        phase_e phase;
        lamp_t  hwy;
        lamp_t  farm;
        logic   load;
        logic   sel_long;
        logic   sel_short;
    } seq_reg_t;

    function automatic lamp_t hwy_lamps(phase_e ph);
        lamp_t l;
        l = '{red: 1'b1, yellow: 1'b0, green: 1'b0};
        if (ph == PH_HWY_GO)   l = '{red: 1'b0, yellow: 1'b0, green: 1'b1};
        if (ph == PH_HWY_WARN) l = '{red: 1'b0, yellow: 1'b1, green: 1'b0};
        return l;
    endfunction

    function automatic lamp_t farm_lamps(phase_e ph);
        lamp_t l;
        l = '{red: 1'b1, yellow: 1'b0, green: 1'b0};
        if (ph == PH_FARM_GO)   l = '{red: 1'b0, yellow: 1'b0, green: 1'b1};
        if (ph == PH_FARM_WARN) l = '{red: 1'b0, yellow: 1'b1, green: 1'b0};
        return l;
    endfunction

endpackage

// File: rtl/fh_sync.sv
module fh_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], d_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign q_sync = sr_q[STAGES-1];
endmodule

// File: rtl/fh_prescale.sv
module fh_prescale #(
    parameter int DIV = 13100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (tick)    cnt_d = '0;
        if (restart) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fh_interval_timer.sv
module fh_interval_timer #(
    parameter int CNT_W      = 4,
    parameter int CNT_STAGES = 2,
    parameter int LONG_SEC   = 30,
    parameter int SHORT_SEC  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel_long,
    input  logic sel_short,
    input  logic tick,
    output logic done
);
    localparam int TOT_W = CNT_W * CNT_STAGES;
    localparam logic [TOT_W-1:0] LONG_VAL  = TOT_W'(LONG_SEC);
    localparam logic [TOT_W-1:0] SHORT_VAL = TOT_W'(SHORT_SEC);

    logic [TOT_W-1:0]      all_q;
    logic [TOT_W-1:0]      load_val;
    logic [CNT_STAGES:0]   low_zero;

    assign load_val    = ({TOT_W{sel_long}} & LONG_VAL) | ({TOT_W{sel_short}} & SHORT_VAL);
    assign low_zero[0] = 1'b1;
    assign done        = (all_q == '0);

    for (genvar gi = 0; gi < CNT_STAGES; gi++) begin : g_stage
        logic [CNT_W-1:0] nib_d, nib_q;

        assign all_q[gi*CNT_W +: CNT_W] = nib_q;
        assign low_zero[gi+1]           = low_zero[gi] && (nib_q == '0);

        always_comb begin
            nib_d = nib_q;
            if (load)                              nib_d = load_val[gi*CNT_W +: CNT_W];
            else if (tick && !done && low_zero[gi]) nib_d = nib_q - 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) nib_q <= LONG_VAL[gi*CNT_W +: CNT_W];
            else        nib_q <= nib_d;
        end
    end
endmodule

// File: rtl/fh_sequencer.sv
module fh_sequencer
    import fh_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     car_waiting,
    input  logic     interval_done,
    output seq_reg_t seq
);
    seq_reg_t cur_q, nxt_d;
    logic     expired;

    localparam seq_reg_t RESET_VAL = '{
        phase:     PH_HWY_GO,
        hwy:       '{red: 1'b0, yellow: 1'b0, green: 1'b1},
        farm:      '{red: 1'b1, yellow: 1'b0, green: 1'b0},
        load:      1'b0,
        sel_long:  1'b0,
        sel_short: 1'b0
    };

    // the done flag is stale during the cycle in which the load is still pending
    assign expired = interval_done && !cur_q.load;

    always_comb begin
        nxt_d           = cur_q;
        nxt_d.load      = 1'b0;
        nxt_d.sel_long  = 1'b0;
        nxt_d.sel_short = 1'b0;
        unique case (cur_q.phase)
            PH_HWY_GO: if (expired && car_waiting) begin
                nxt_d.phase     = PH_HWY_WARN;
                nxt_d.load      = 1'b1;
                nxt_d.sel_short = 1'b1;
            end
            PH_HWY_WARN: if (expired) nxt_d.phase = PH_TO_FARM;
            PH_TO_FARM: begin
                nxt_d.phase    = PH_FARM_GO;
                nxt_d.load     = 1'b1;
                nxt_d.sel_long = 1'b1;
            end
            PH_FARM_GO: if (expired) begin
                nxt_d.phase     = PH_FARM_WARN;
                nxt_d.load      = 1'b1;
                nxt_d.sel_short = 1'b1;
            end
            PH_FARM_WARN: if (expired) nxt_d.phase = PH_TO_HWY;
            PH_TO_HWY: begin
                nxt_d.phase    = PH_HWY_GO;
                nxt_d.load     = 1'b1;
                nxt_d.sel_long = 1'b1;
            end
            default: nxt_d.phase = PH_HWY_GO;
        endcase
        nxt_d.hwy  = hwy_lamps(nxt_d.phase);
        nxt_d.farm = farm_lamps(nxt_d.phase);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= RESET_VAL;
        else        cur_q <= nxt_d;
    end

    assign seq = cur_q;
endmodule

// File: rtl/farm_hwy_ctrl.sv
module farm_hwy_ctrl
    import fh_ctrl_pkg::*;
#(
    parameter int TICK_DIV    = 13100,
    parameter int LONG_SEC    = 30,
    parameter int SHORT_SEC   = 5,
    parameter int CNT_W       = 4,
    parameter int CNT_STAGES  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic farm_sensor_async,
    output logic hwy_red,
    output logic hwy_yellow,
    output logic hwy_green,
    output logic farm_red,
    output logic farm_yellow,
    output logic farm_green,
    output logic start_long,
    output logic start_short,
    output logic load_cnt
);
    seq_reg_t seq;
    logic     car_sync;
    logic     sec_tick;
    logic     ivl_done;

    fh_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (farm_sensor_async),
        .q_sync  (car_sync)
    );

    fh_prescale #(.DIV(TICK_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (seq.load),
        .tick    (sec_tick)
    );

    fh_interval_timer #(
        .CNT_W      (CNT_W),
        .CNT_STAGES (CNT_STAGES),
        .LONG_SEC   (LONG_SEC),
        .SHORT_SEC  (SHORT_SEC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (seq.load),
        .sel_long  (seq.sel_long),
        .sel_short (seq.sel_short),
        .tick      (sec_tick),
        .done      (ivl_done)
    );

    fh_sequencer u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .car_waiting   (car_sync),
        .interval_done (ivl_done),
        .seq           (seq)
    );

    assign hwy_red     = seq.hwy.red;
    assign hwy_yellow  = seq.hwy.yellow;
    assign hwy_green   = seq.hwy.green;
    assign farm_red    = seq.farm.red;
    assign farm_yellow = seq.farm.yellow;
    assign farm_green  = seq.farm.green;
    assign start_long  = seq.sel_long;
    assign start_short = seq.sel_short;
    assign load_cnt    = seq.load;
endmodule

// File: rtl/farm_hwy_ctrl_chk.sv
module farm_hwy_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic hwy_red,
    input logic hwy_yellow,
    input logic hwy_green,
    input logic farm_red,
    input logic farm_yellow,
    input logic farm_green,
    input logic start_long,
    input logic start_short,
    input logic load_cnt
);
    AST_HWY_ONE_LAMP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({hwy_red, hwy_yellow, hwy_green}) == 1); // R2
    AST_FARM_ONE_LAMP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({farm_red, farm_yellow, farm_green}) == 1); // R2
    AST_HWY_GREEN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        hwy_green |=> (hwy_green || hwy_yellow)); // R3
    AST_FARM_GREEN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        farm_green |=> (farm_green || farm_yellow)); // R3
    AST_HWY_YELLOW_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        hwy_yellow |=> (hwy_yellow || (hwy_red && farm_red))); // R7
    AST_FARM_YELLOW_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        farm_yellow |=> (farm_yellow || (hwy_red && farm_red))); // R7
    AST_ALL_RED_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_red && farm_red) |=> !(hwy_red && farm_red)); // R7
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_cnt |=> !load_cnt); // R9
    AST_LOAD_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        load_cnt |-> $countones({start_long, start_short}) == 1); // R9
    AST_SELECT_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_cnt |-> !(start_long || start_short)); // R9
    AST_ONE_ROAD_RED: assert property (@(posedge clk) disable iff (!rst_n)
        hwy_red || farm_red); // R10
endmodule

bind farm_hwy_ctrl farm_hwy_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hwy_red     (hwy_red),
    .hwy_yellow  (hwy_yellow),
    .hwy_green   (hwy_green),
    .farm_red    (farm_red),
    .farm_yellow (farm_yellow),
    .farm_green  (farm_green),
    .start_long  (start_long),
    .start_short (start_short),
    .load_cnt    (load_cnt)
);

// File: tb/farm_hwy_ctrl_tb.sv
module farm_hwy_ctrl_tb;
    localparam int D  = 3;
    localparam int LG = 30;
    localparam int SH = 5;
    localparam int T_LONG  = LG * D + 2;
    localparam int T_SHORT = SH * D + 2;

    // lamp vector order: {hwy red, hwy yellow, hwy green, farm red, farm yellow, farm green}
    localparam logic [5:0] P_HG = 6'b001_100;
    localparam logic [5:0] P_HY = 6'b010_100;
    localparam logic [5:0] P_RR = 6'b100_100;
    localparam logic [5:0] P_FG = 6'b100_001;
    localparam logic [5:0] P_FY = 6'b100_010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sensor = 1'b0;
    logic hwy_red, hwy_yellow, hwy_green, farm_red, farm_yellow, farm_green;
    logic start_long, start_short, load_cnt;
    logic [5:0] lamps;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    assign lamps = {hwy_red, hwy_yellow, hwy_green, farm_red, farm_yellow, farm_green};

    farm_hwy_ctrl #(.TICK_DIV(D), .LONG_SEC(LG), .SHORT_SEC(SH)) u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .farm_sensor_async (sensor),
        .hwy_red           (hwy_red),
        .hwy_yellow        (hwy_yellow),
        .hwy_green         (hwy_green),
        .farm_red          (farm_red),
        .farm_yellow       (farm_yellow),
        .farm_green        (farm_green),
        .start_long        (start_long),
        .start_short       (start_short),
        .load_cnt          (load_cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // counts edges until the lamp pattern leaves p; checks lamp sanity on the way
    task automatic count_while(input logic [5:0] p, output int n);
        int ok;
        ok = 1;
        n = 0;
        do begin
            step();
            n++;
            if ($countones(lamps[5:3]) != 1 || $countones(lamps[2:0]) != 1) ok = 0;
            if (!lamps[5] && !lamps[2]) ok = 0;
        end while (lamps == p && n < 5000);
        check("R2/R10 lamp sanity", ok, 1);
    endtask

    task automatic enter_phase(input string req, input logic [5:0] p, input bit lng,
                               output int n);
        int m;
        check(req, int'(lamps), int'(p));
        check("R9 load on entry", int'(load_cnt), 1);
        check("R9 long select", int'(start_long), int'(lng));
        check("R9 short select", int'(start_short), int'(!lng));
        step();
        check("R9 strobes one cycle", int'({load_cnt, start_long, start_short}), 0);
        count_while(p, m);
        n = m + 1;
    endtask

    task automatic t_reset();
        int n;
        sensor = 1'b1;
        rst_n  = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset lamps", int'(lamps), int'(P_HG));
        check("R1 reset strobes", int'({load_cnt, start_long, start_short}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        count_while(P_HG, n);
        check("R4 first green from reset", n, LG * D + 1);
    endtask

    task automatic t_farm_cycle(input bit keep_sensor);
        int n;
        enter_phase("R3 highway green to yellow", P_HY, 1'b0, n);
        check("R6 highway yellow length", n, T_SHORT);
        check("R7 all red after highway", int'(lamps), int'(P_RR));
        check("R9 no strobe in all red", int'({load_cnt, start_long, start_short}), 0);
        count_while(P_RR, n);
        check("R7 all red one cycle", n, 1);
        if (!keep_sensor) sensor = 1'b0;
        enter_phase("R7 farm green after all red", P_FG, 1'b1, n);
        check("R8 farm green length", n, T_LONG);
        enter_phase("R3 farm green to yellow", P_FY, 1'b0, n);
        check("R6 farm yellow length", n, T_SHORT);
        check("R7 all red after farm", int'(lamps), int'(P_RR));
        count_while(P_RR, n);
        check("R7 all red one cycle", n, 1);
    endtask

    task automatic t_hold_green();
        int n;
        check("R7 highway green after all red", int'(lamps), int'(P_HG));
        check("R9 long load for highway", int'({load_cnt, start_long, start_short}), 3'b110);
        repeat (150) step();
        check("R5 green held without vehicle", int'(lamps), int'(P_HG));
        sensor = 1'b1;
        count_while(P_HG, n);
        check("R5 sensor latency", n, 3);
    endtask

    task automatic t_min_green();
        int n;
        enter_phase("R7 highway green re-entry", P_HG, 1'b1, n);
        check("R4 minimum highway green", n, T_LONG);
        check("R3 highway green ends in yellow", int'(lamps), int'(P_HY));
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_farm_cycle(1'b0);
        t_hold_green();
        t_farm_cycle(1'b1);
        t_min_green();
        finish_run();
    end
endmodule